// File: doc/BRIEF.md
# Dual-Clock Symbol Stream Integrity Monitor

This block is a passive observer placed across one data channel that crosses between two unrelated clock domains, such as a single channel of an asynchronous bus bridge. It never drives the monitored path. It does not keep a copy of every item in flight. It tracks one chosen data value, the symbol, and counts how often that value passes each side of the crossing on qualified transfers. It then compares the counts and the ordering across the two clocks. From that comparison it can tell whether the channel lost, duplicated, invented or shuffled data.

The producer-side tracker works on the source clock. It counts symbol transfers in a small counter, and the count is carried as a Gray code. A multi-stage synchronizer brings that code into the destination clock. The destination tracker checks every symbol that leaves the channel against the synchronized source count. A one-cycle drain pulse, issued by the environment after traffic has settled, triggers a final loss check and raises the done indication.

Two tracking modes are supported. In single mode the symbol passes exactly once. In pair mode it passes on exactly two back-to-back qualified transfers. The environment must hold the symbol and the mode constant while out of reset.

Top module: `stream_symbol_checker`

## Requirements
- R1: A side counts an item as transferred only on a clock edge where that side's fire qualifier is 1. Symbol-valued data with fire at 0 changes no flag and no count.
- R2: If the symbol input or the mode input changes between two source-clock edges while reset is released, `err_cfg` is set.
- R3: Some source transfers break the stimulus contract, and each one sets `err_cfg`. In single mode (mode=0) this is a second symbol transfer. In pair mode (mode=1) it is a symbol transfer that is neither the first one nor the one directly after the first.
- R4: The destination can carry more symbols than the mode allows: one in single mode, two in pair mode. Any destination symbol transfer after that limit sets `err_dup`.
- R5: `err_create` is set by a destination symbol transfer that arrives while the synchronized source symbol count is not greater than the destination count already seen.
- R6: A drain pulse sets `err_loss` if the synchronized source symbol count exceeds the destination symbol count.
- R7: In pair mode, `err_order` is set when the second destination symbol transfer does not directly follow the first one, with no other qualified destination transfer between them.
- R8: All flags are 0 after reset. Each flag, once set, stays set until reset.
- R9: `done` is 1 from the destination edge that samples `drain` at 1 until the next reset.
- R10: A faithful channel sets no error flag in either mode, including when idle cycles carry the symbol value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Shared synchronous active-low reset, sampled by both clocks |
| src_clk | input | 1 | Source-side clock |
| src_data | input | DATA_W | Source-side data |
| src_fire | input | 1 | Source transfer qualifier (for example valid AND ready) |
| dst_clk | input | 1 | Destination-side clock |
| dst_data | input | DATA_W | Destination-side data |
| dst_fire | input | 1 | Destination transfer qualifier |
| symbol | input | DATA_W | Tracked value, held constant while out of reset |
| mode | input | 1 | 0 = single symbol, 1 = two consecutive symbols |
| drain | input | 1 | Destination-clock pulse requesting the final loss check |
| err_cfg | output | 1 | Sticky configuration or source contract error (source clock) |
| err_loss | output | 1 | Sticky loss error (destination clock) |
| err_dup | output | 1 | Sticky duplication error (destination clock) |
| err_create | output | 1 | Sticky creation error (destination clock) |
| err_order | output | 1 | Sticky reordering error (destination clock) |
| done | output | 1 | Drain seen (destination clock) |

## Verification
`err_cfg` appears one source edge after the offending transfer or input change. The destination flags and `done` appear one destination edge after the transfer or drain that causes them. A change in the source symbol count becomes visible to the destination logic only after SYNC_STAGES+1 destination edges. The bench therefore leaves at least six destination cycles between the end of the source stream and the first destination transfer, and the same margin before the drain. A behavioural reference model is updated on each rising edge, and every flag is compared against it on the falling edge of its own clock, once the registered output is stable.

// File: rtl/stream_chk_pkg.sv
// Package: shared types and Gray helpers for the symbol stream monitor.
// Assumes symbol counts never exceed two, so two bits suffice.
package stream_chk_pkg;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_PAIR   = 1'b1
    } trk_mode_e;

    localparam int CNT_W = 2;

    // Convert a binary count to its Gray form.
    function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Convert a Gray code back to a binary count.
    function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/bit_sync.sv
// Multi-flop synchronizer for a bus whose value changes at most one bit
// at a time (Gray or monotonic single bit). Assumes STAGES >= 2.
module bit_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture flop of the crossing.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= d;
                end
            end else begin : g_rest
                // Further settling flops.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[s] <= '0;
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/src_tracker.sv
// Source-side tracker: counts symbol transfers (saturating at the mode
// limit), publishes the count as Gray code from a flop, and flags input
// contract breaks and changes of symbol or mode while out of reset.
module src_tracker
    import stream_chk_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] symbol,
    input  logic              mode,
    output logic [CNT_W-1:0]  cnt_gray,
    output logic              err_cfg
);
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic              last_sym, last_nxt;
    logic [DATA_W-1:0] sym_q;
    logic              mode_q;
    logic              armed;
    logic              viol, cfg_chg;

    // Next count and contract check for the current transfer.
    always_comb begin
        cnt_nxt  = cnt;
        last_nxt = last_sym;
        viol     = 1'b0;
        if (fire) begin
            last_nxt = (data == symbol);
            if (data == symbol) begin
                if (cnt == '0)
                    cnt_nxt = CNT_W'(1);
                else if (mode == MODE_PAIR && cnt == CNT_W'(1) && last_sym)
                    cnt_nxt = CNT_W'(2);
                else
                    viol = 1'b1;
            end
        end
        cfg_chg = armed && ((symbol != sym_q) || (mode != mode_q));
    end

    // State update and sticky configuration flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            cnt_gray <= '0;
            last_sym <= 1'b0;
            sym_q    <= '0;
            mode_q   <= 1'b0;
            armed    <= 1'b0;
            err_cfg  <= 1'b0;
        end else begin
            cnt      <= cnt_nxt;
            cnt_gray <= bin2gray(cnt_nxt);
            last_sym <= last_nxt;
            sym_q    <= symbol;
            mode_q   <= mode;
            armed    <= 1'b1;
            err_cfg  <= err_cfg | viol | cfg_chg;
        end
    end
endmodule

// File: rtl/dst_tracker.sv
// Destination-side tracker: compares each outgoing symbol with the
// synchronized source count and raises duplication, creation, ordering
// and (on drain) loss flags. Assumes the channel latency exceeds the
// synchronizer delay, as any real clock-crossing channel's does.
module dst_tracker
    import stream_chk_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] symbol,
    input  logic              mode,
    input  logic [CNT_W-1:0]  src_gray,
    input  logic              drain,
    output logic              err_loss,
    output logic              err_dup,
    output logic              err_create,
    output logic              err_order,
    output logic              done
);
    logic [CNT_W-1:0] src_cnt, limit;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             last_sym, last_nxt;
    logic             dup_hit, create_hit, order_hit, loss_hit;

    assign src_cnt = gray2bin(src_gray);
    assign limit   = (mode == MODE_PAIR) ? CNT_W'(2) : CNT_W'(1);

    // Classify the current destination transfer.
    always_comb begin
        cnt_nxt    = cnt;
        last_nxt   = last_sym;
        dup_hit    = 1'b0;
        create_hit = 1'b0;
        order_hit  = 1'b0;
        if (fire) begin
            last_nxt = (data == symbol);
            if (data == symbol) begin
                if (cnt == limit) begin
                    dup_hit = 1'b1;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                    if (src_cnt <= cnt)
                        create_hit = 1'b1;
                    else if (mode == MODE_PAIR && cnt == CNT_W'(1) && !last_sym)
                        order_hit = 1'b1;
                end
            end
        end
        loss_hit = drain && (src_cnt > cnt);
    end

    // State update and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            last_sym   <= 1'b0;
            err_loss   <= 1'b0;
            err_dup    <= 1'b0;
            err_create <= 1'b0;
            err_order  <= 1'b0;
            done       <= 1'b0;
        end else begin
            cnt        <= cnt_nxt;
            last_sym   <= last_nxt;
            err_loss   <= err_loss   | loss_hit;
            err_dup    <= err_dup    | dup_hit;
            err_create <= err_create | create_hit;
            err_order  <= err_order  | order_hit;
            done       <= done       | drain;
        end
    end
endmodule

// File: rtl/stream_symbol_checker.sv
// Top: passive integrity monitor for one clock-crossing data channel.
// Assumes rst_n is held low for several cycles of both clocks, and that
// symbol and mode stay constant while rst_n is high.
module stream_symbol_checker
    import stream_chk_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              rst_n,
    input  logic              src_clk,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_fire,
    input  logic              dst_clk,
    input  logic [DATA_W-1:0] dst_data,
    input  logic              dst_fire,
    input  logic [DATA_W-1:0] symbol,
    input  logic              mode,
    input  logic              drain,
    output logic              err_cfg,
    output logic              err_loss,
    output logic              err_dup,
    output logic              err_create,
    output logic              err_order,
    output logic              done
);
    logic [CNT_W-1:0] src_gray, src_gray_sync;

    src_tracker #(.DATA_W(DATA_W)) u_src (
        .clk      (src_clk),
        .rst_n    (rst_n),
        .fire     (src_fire),
        .data     (src_data),
        .symbol   (symbol),
        .mode     (mode),
        .cnt_gray (src_gray),
        .err_cfg  (err_cfg)
    );

    bit_sync #(.WIDTH(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (dst_clk),
        .rst_n (rst_n),
        .d     (src_gray),
        .q     (src_gray_sync)
    );

    dst_tracker #(.DATA_W(DATA_W)) u_dst (
        .clk        (dst_clk),
        .rst_n      (rst_n),
        .fire       (dst_fire),
        .data       (dst_data),
        .symbol     (symbol),
        .mode       (mode),
        .src_gray   (src_gray_sync),
        .drain      (drain),
        .err_loss   (err_loss),
        .err_dup    (err_dup),
        .err_create (err_create),
        .err_order  (err_order),
        .done       (done)
    );
endmodule

// File: rtl/stream_symbol_checker_sva.sv
// Checker bound to the top: relates flag rises to the port activity that
// must have caused them, and checks that flags hold.
module stream_symbol_checker_sva #(
    parameter int DATA_W = 16
) (
    input logic              rst_n,
    input logic              src_clk,
    input logic              dst_clk,
    input logic [DATA_W-1:0] dst_data,
    input logic              dst_fire,
    input logic [DATA_W-1:0] symbol,
    input logic              mode,
    input logic              drain,
    input logic              err_cfg,
    input logic              err_loss,
    input logic              err_dup,
    input logic              err_create,
    input logic              err_order,
    input logic              done
);
    AST_DUP_NEEDS_SYMBOL: assert property (@(posedge dst_clk) disable iff (!rst_n)
        $rose(err_dup) |-> $past(dst_fire && dst_data == symbol)); // R4
    AST_CREATE_NEEDS_SYMBOL: assert property (@(posedge dst_clk) disable iff (!rst_n)
        $rose(err_create) |-> $past(dst_fire && dst_data == symbol)); // R5
    AST_LOSS_ON_DRAIN: assert property (@(posedge dst_clk) disable iff (!rst_n)
        $rose(err_loss) |-> $past(drain)); // R6
    AST_ORDER_PAIR_ONLY: assert property (@(posedge dst_clk) disable iff (!rst_n)
        $rose(err_order) |-> $past(mode && dst_fire && dst_data == symbol)); // R7
    AST_DST_STICKY: assert property (@(posedge dst_clk) disable iff (!rst_n)
        (err_loss && err_dup && err_create && err_order) |=> (err_loss && err_dup && err_create && err_order)); // R8
    AST_DUP_HOLDS: assert property (@(posedge dst_clk) disable iff (!rst_n)
        err_dup |=> err_dup); // R8
    AST_CFG_HOLDS: assert property (@(posedge src_clk) disable iff (!rst_n)
        err_cfg |=> err_cfg); // R8
    AST_DONE_AFTER_DRAIN: assert property (@(posedge dst_clk) disable iff (!rst_n)
        drain |=> done); // R9
endmodule

bind stream_symbol_checker stream_symbol_checker_sva #(.DATA_W(DATA_W)) u_sva (
    .rst_n      (rst_n),
    .src_clk    (src_clk),
    .dst_clk    (dst_clk),
    .dst_data   (dst_data),
    .dst_fire   (dst_fire),
    .symbol     (symbol),
    .mode       (mode),
    .drain      (drain),
    .err_cfg    (err_cfg),
    .err_loss   (err_loss),
    .err_dup    (err_dup),
    .err_create (err_create),
    .err_order  (err_order),
    .done       (done)
);

// File: tb/sim_stream_symbol_checker.sv
// Bench: a queue stands in for the clock-crossing channel, with faults
// injected on replay. A behavioural model is compared on every falling edge.
module sim_stream_symbol_checker;
    localparam int CLK_PERIOD = 10;
    localparam int DST_PERIOD = 14;
    localparam int DW         = 16;
    localparam logic [DW-1:0] SYM = 16'hA5A5;

    logic          rst_n = 1'b0;
    logic          src_clk = 1'b0, dst_clk = 1'b0;
    logic [DW-1:0] src_data = SYM, dst_data = SYM, symbol = SYM;
    logic          src_fire = 1'b0, dst_fire = 1'b0, mode = 1'b0, drain = 1'b0;
    logic          err_cfg, err_loss, err_dup, err_create, err_order, done;

    int n_checks = 0, n_bad = 0;
    bit cmp_en = 1'b0;
    logic [DW-1:0] chan_q[$];

    // Model state
    int m_scnt, m_dcnt;
    bit m_slast, m_dlast, m_armed, m_cfg, m_loss, m_dup, m_create, m_order, m_done;
    logic [DW-1:0] m_sym;
    logic m_mode;

    always #(CLK_PERIOD/2) src_clk = ~src_clk;
    always #(DST_PERIOD/2) dst_clk = ~dst_clk;

    stream_symbol_checker #(.DATA_W(DW)) u0 (
        .rst_n(rst_n), .src_clk(src_clk), .src_data(src_data), .src_fire(src_fire),
        .dst_clk(dst_clk), .dst_data(dst_data), .dst_fire(dst_fire),
        .symbol(symbol), .mode(mode), .drain(drain),
        .err_cfg(err_cfg), .err_loss(err_loss), .err_dup(err_dup),
        .err_create(err_create), .err_order(err_order), .done(done));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Source-side reference model.
    always @(posedge src_clk) begin
        if (!rst_n) begin
            m_scnt = 0; m_slast = 0; m_armed = 0; m_cfg = 0;
        end else begin
            if (m_armed && (symbol != m_sym || mode != m_mode)) m_cfg = 1;
            m_sym = symbol; m_mode = mode; m_armed = 1;
            if (src_fire) begin
                if (src_data == symbol) begin
                    if (m_scnt == 0) m_scnt = 1;
                    else if (mode && m_scnt == 1 && m_slast) m_scnt = 2;
                    else m_cfg = 1;
                end
                m_slast = (src_data == symbol);
            end
        end
    end

    // Destination-side reference model.
    always @(posedge dst_clk) begin
        if (!rst_n) begin
            m_dcnt = 0; m_dlast = 0; m_loss = 0; m_dup = 0;
            m_create = 0; m_order = 0; m_done = 0;
        end else begin
            if (drain) begin
                if (m_scnt > m_dcnt) m_loss = 1;
                m_done = 1;
            end
            if (dst_fire) begin
                if (dst_data == symbol) begin
                    if (m_dcnt == (mode ? 2 : 1)) m_dup = 1;
                    else begin
                        if (m_scnt <= m_dcnt) m_create = 1;
                        else if (mode && m_dcnt == 1 && !m_dlast) m_order = 1;
                        m_dcnt++;
                    end
                end
                m_dlast = (dst_data == symbol);
            end
        end
    end

    // Per-cycle comparison, away from the active edges.
    always @(negedge src_clk) if (cmp_en) chk("R3 cfg per cycle", err_cfg, m_cfg);
    always @(negedge dst_clk) if (cmp_en) begin
        chk("R6 loss per cycle", err_loss, m_loss);
        chk("R4 dup per cycle", err_dup, m_dup);
        chk("R5 create per cycle", err_create, m_create);
        chk("R7 order per cycle", err_order, m_order);
        chk("R9 done per cycle", done, m_done);
    end

    task automatic do_reset(input logic md);
        @(negedge src_clk);
        rst_n = 1'b0; mode = md; symbol = SYM;
        src_fire = 0; dst_fire = 0; drain = 0;
        src_data = SYM; dst_data = SYM;
        chan_q.delete();
        repeat (4) @(negedge dst_clk);
        @(negedge src_clk);
        rst_n = 1'b1;
    endtask

    // One source transfer, then one idle cycle carrying the symbol (R1).
    task automatic src_push(input logic [DW-1:0] v);
        @(negedge src_clk); src_fire = 1; src_data = v; chan_q.push_back(v);
        @(negedge src_clk); src_fire = 0; src_data = SYM;
    endtask

    task automatic src_seq(input int n, input int p1, input int p2);
        for (int i = 0; i < n; i++)
            src_push((i == p1 || i == p2) ? SYM : DW'(16'h0100 + i));
    endtask

    task automatic dst_push(input logic [DW-1:0] v);
        @(negedge dst_clk); dst_fire = 1; dst_data = v;
        @(negedge dst_clk); dst_fire = 0; dst_data = SYM;
    endtask

    // Replay the channel with a fault: 0 none, 1 drop, 2 duplicate,
    // 3 swap last symbol with next item, 4 corrupt first item to symbol.
    task automatic replay(input int fault);
        logic [DW-1:0] it[$];
        logic [DW-1:0] tmp;
        int first, last;
        it = chan_q; chan_q.delete();
        first = -1; last = -1;
        for (int i = 0; i < it.size(); i++)
            if (it[i] == SYM) begin if (first < 0) first = i; last = i; end
        case (fault)
            1: if (first >= 0) it.delete(first);
            2: if (first >= 0) it.insert(first, SYM);
            3: if (last >= 0 && last + 1 < it.size()) begin
                   tmp = it[last]; it[last] = it[last+1]; it[last+1] = tmp;
               end
            4: it[0] = SYM;
            default: ;
        endcase
        repeat (6) @(negedge dst_clk);
        for (int i = 0; i < it.size(); i++) dst_push(it[i]);
    endtask

    task automatic do_drain;
        repeat (6) @(negedge dst_clk);
        drain = 1; @(negedge dst_clk); drain = 0;
        @(negedge dst_clk);
    endtask

    // Final flag vector {cfg, loss, dup, create, order, done}.
    task automatic expect_flags(input string req, input logic [5:0] e);
        repeat (3) @(negedge src_clk);
        @(negedge dst_clk);
        chk({req, " cfg"},    err_cfg,    e[5]);
        chk({req, " loss"},   err_loss,   e[4]);
        chk({req, " dup"},    err_dup,    e[3]);
        chk({req, " create"}, err_create, e[2]);
        chk({req, " order"},  err_order,  e[1]);
        chk({req, " done"},   done,       e[0]);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        cmp_en = 1'b1;
        expect_flags("R8 reset state", 6'b000000);

        // R10 single clean, R9 done after drain
        src_seq(8, 3, -1); replay(0); do_drain();
        expect_flags("R10 single clean", 6'b000001);

        // R1: destination idles on the symbol before source sees it
        do_reset(1'b0);
        repeat (10) @(negedge dst_clk);
        src_seq(5, 2, -1); replay(0); do_drain();
        expect_flags("R1 idle symbol ignored", 6'b000001);

        // R6 single drop
        do_reset(1'b0);
        src_seq(6, 2, -1); replay(1); do_drain();
        expect_flags("R6 single loss", 6'b010001);

        // R4 single duplicate, then R8 stickiness and clear
        do_reset(1'b0);
        src_seq(6, 2, -1); replay(2); do_drain();
        expect_flags("R4 single dup", 6'b001001);
        repeat (20) @(negedge dst_clk);
        expect_flags("R8 dup held", 6'b001001);
        do_reset(1'b0);
        expect_flags("R8 cleared by reset", 6'b000000);

        // R5 creation: no symbol sent, one corrupted into it
        do_reset(1'b0);
        src_seq(6, -1, -1); replay(4); do_drain();
        expect_flags("R5 creation", 6'b000101);

        // R10 pair clean
        do_reset(1'b1);
        src_seq(7, 2, 3); replay(0); do_drain();
        expect_flags("R10 pair clean", 6'b000001);

        // R7 pair swap
        do_reset(1'b1);
        src_seq(6, 2, 3); replay(3); do_drain();
        expect_flags("R7 pair reorder", 6'b000011);

        // R6 pair drop one
        do_reset(1'b1);
        src_seq(6, 2, 3); replay(1); do_drain();
        expect_flags("R6 pair loss", 6'b010001);

        // R3 single: second input symbol
        do_reset(1'b0);
        src_seq(6, 1, 4);
        expect_flags("R3 single contract", 6'b100000);

        // R3 pair: symbols not back-to-back
        do_reset(1'b1);
        src_seq(6, 1, 3);
        expect_flags("R3 pair contract", 6'b100000);

        // R2 symbol change
        do_reset(1'b0);
        repeat (3) @(negedge src_clk);
        symbol = 16'h1234; @(negedge src_clk); symbol = SYM;
        expect_flags("R2 symbol change", 6'b100000);

        // R2 mode change
        do_reset(1'b0);
        repeat (3) @(negedge src_clk);
        mode = 1'b1; @(negedge src_clk); mode = 1'b0;
        expect_flags("R2 mode change", 6'b100000);

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule